// File: doc/BRIEF.md
# Hamming single-error-correcting path with fault injection

This block guards one byte on its way through storage. The byte is encoded into a 12-bit interleaved Hamming codeword. An even parity check bit sits at each power-of-two position, and the data bits fill the other positions. The codeword then passes a self-test multiplexer. When the fault select is high, the multiplexer XORs the codeword with a caller-supplied mask, which models soft errors. A decoder recomputes the checks over the received word. It reads the resulting syndrome as the position of the bit to invert, and rebuilds the byte.

Encoder, fault stage and decoder are combinational. One output register, enabled by a valid strobe, captures the corrected byte, the syndrome and two flags. The width of the data word is a parameter. The number of check bits and the codeword length follow from it, and the defaults give 8 data bits, 4 check bits and 12 codeword positions.

Top module: `ham_ecc_path`

## Requirements
- R1: Codeword positions are numbered 1 to 12. Check bits occupy positions 1, 2, 4 and 8. Data bits d0 to d7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order.
- R2: The check bit at position 2^k is the even parity (XOR) of every data bit whose position number has bit k set.
- R3: With fault_sel_i low, the fault mask has no effect: data_o equals the input byte, syndrome_o is 0 and err_o is low.
- R4: With fault_sel_i high, the decoder receives the codeword XOR fault_mask_i, where mask bit i flips codeword position i+1. An all-zero mask yields no error.
- R5: syndrome_o is the binary XOR of the position numbers of all flipped bits. err_o is high exactly when syndrome_o is nonzero.
- R6: A single flipped data position is corrected: data_o equals the input byte, err_o is high and uncorr_o is low.
- R7: A single flipped check position (syndrome 1, 2, 4 or 8) raises err_o and leaves data_o equal to the input byte.
- R8: A syndrome of 13, 14 or 15 raises uncorr_o and err_o. No bit is inverted, so data_o carries the received data bits as they are.
- R9: A syndrome from 1 to 12 inverts exactly the codeword position it names before the data is extracted, even when more than one bit was flipped.
- R10: The outputs load on a rising clock edge while valid_i is high and hold their values while valid_i is low.
- R11: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load strobe for the output register |
| data_i | input | 8 | Byte to protect |
| fault_sel_i | input | 1 | High selects the corrupted codeword |
| fault_mask_i | input | 12 | Bit i flips codeword position i+1 |
| data_o | output | 8 | Corrected byte |
| syndrome_o | output | 4 | Recomputed check syndrome |
| err_o | output | 1 | Nonzero syndrome |
| uncorr_o | output | 1 | Syndrome points outside the codeword |

## Verification
The hardest state to reach is an out-of-range syndrome (13 to 15). A single flip never produces one, so the bench builds two-bit masks whose position numbers XOR past 12, such as positions 5 and 8. Other double-bit masks land on a valid position and cause a miscorrection, which checks that the decoder inverts exactly the named position. A reference model in the bench encodes each byte and applies the mask. It then computes the syndrome as an XOR of position numbers, which is independent of the mask form used in the design.

// File: rtl/ham_pkg.sv
package ham_pkg;
  localparam int MAX_POS = 256;

  // smallest r with 2^r >= data bits + r + 1
  function automatic int chk_bits(input int dw);
    int r;
    r = 0;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // 1-based codeword position of data bit i
  function automatic int data_pos(input int i);
    int cnt;
    int pos;
    cnt = 0;
    pos = 0;
    for (int p = 1; p < MAX_POS; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == i && pos == 0) pos = p;
        cnt++;
      end
    end
    return pos;
  endfunction

  // codeword positions covered by syndrome bit j
  function automatic logic [MAX_POS-1:0] syn_cover(input int j, input int cw_w);
    logic [MAX_POS-1:0] m;
    m = '0;
    for (int p = 1; p <= cw_w; p++)
      if (((p >> j) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

  // data bits covered by check bit j
  function automatic logic [MAX_POS-1:0] data_cover(input int j, input int dw);
    logic [MAX_POS-1:0] m;
    m = '0;
    for (int i = 0; i < dw; i++)
      if (((data_pos(i) >> j) & 1) == 1) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ham_enc.sv
module ham_enc
  import ham_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CW_W   = 12
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign cw_o[data_pos(i)-1] = data_i[i];
  end

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    localparam logic [MAX_POS-1:0] COVER = data_cover(j, DATA_W);
    assign cw_o[(1 << j) - 1] = ^(data_i & COVER[DATA_W-1:0]);
  end
endmodule

// File: rtl/ham_fault_mux.sv
module ham_fault_mux #(
  parameter int CW_W = 12
) (
  input  logic            sel_i,
  input  logic [CW_W-1:0] cw_i,
  input  logic [CW_W-1:0] mask_i,
  output logic [CW_W-1:0] cw_o
);
  logic [CW_W-1:0] bad_cw;

  assign bad_cw = cw_i ^ mask_i;
  assign cw_o   = sel_i ? bad_cw : cw_i;
endmodule

// File: rtl/ham_dec.sv
module ham_dec
  import ham_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CW_W   = 12
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syn_o,
  output logic              err_o,
  output logic              uncorr_o
);
  logic [CW_W-1:0] flip;
  logic [CW_W-1:0] fixed_cw;

  for (genvar j = 0; j < CHK_W; j++) begin : g_syn
    localparam logic [MAX_POS-1:0] COVER = syn_cover(j, CW_W);
    assign syn_o[j] = ^(cw_i & COVER[CW_W-1:0]);
  end

  // syndrome selects the position to invert; out-of-range values select none
  for (genvar p = 1; p <= CW_W; p++) begin : g_flip
    assign flip[p-1] = (syn_o == CHK_W'(p));
  end

  assign fixed_cw = cw_i ^ flip;

  for (genvar i = 0; i < DATA_W; i++) begin : g_out
    assign data_o[i] = fixed_cw[data_pos(i)-1];
  end

  assign err_o    = |syn_o;
  assign uncorr_o = (syn_o > CHK_W'(CW_W));
endmodule

// File: rtl/ham_out_reg.sv
module ham_out_reg #(
  parameter int W       = 14,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_r <= '0;
      else if (load_i) q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/ham_ecc_path.sv
module ham_ecc_path
  import ham_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fault_sel_i,
  input  logic [CW_W-1:0]   fault_mask_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic              err_o,
  output logic              uncorr_o
);
  localparam int PACK_W = DATA_W + CHK_W + 2;

  logic [CW_W-1:0]   tx_cw;
  logic [CW_W-1:0]   rx_cw;
  logic [DATA_W-1:0] dec_data;
  logic [CHK_W-1:0]  dec_syn;
  logic              dec_err;
  logic              dec_unc;
  logic [PACK_W-1:0] pack_d;
  logic [PACK_W-1:0] pack_q;

  ham_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
    .data_i (data_i),
    .cw_o   (tx_cw)
  );

  ham_fault_mux #(.CW_W(CW_W)) u_fault (
    .sel_i  (fault_sel_i),
    .cw_i   (tx_cw),
    .mask_i (fault_mask_i),
    .cw_o   (rx_cw)
  );

  ham_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
    .cw_i     (rx_cw),
    .data_o   (dec_data),
    .syn_o    (dec_syn),
    .err_o    (dec_err),
    .uncorr_o (dec_unc)
  );

  assign pack_d = {dec_data, dec_syn, dec_err, dec_unc};

  ham_out_reg #(.W(PACK_W), .REG_OUT(REG_OUT)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .d_i    (pack_d),
    .q_o    (pack_q)
  );

  assign {data_o, syndrome_o, err_o, uncorr_o} = pack_q;
endmodule

// File: rtl/ham_ecc_path_chk.sv
module ham_ecc_path_chk #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CW_W   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              fault_sel_i,
  input logic [CW_W-1:0]   fault_mask_i,
  input logic [DATA_W-1:0] data_o,
  input logic [CHK_W-1:0]  syndrome_o,
  input logic              err_o,
  input logic              uncorr_o
);
  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({data_o, syndrome_o, err_o, uncorr_o}));

  // R3
  clean_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fault_sel_i) |=> (!err_o && syndrome_o == '0 && data_o == $past(data_i)));

  // R4
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fault_sel_i && fault_mask_i == '0) |=> !err_o);

  // R6
  single_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fault_sel_i && $countones(fault_mask_i) == 1)
      |=> (err_o && !uncorr_o && data_o == $past(data_i)));

  // R8
  uncorr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> (err_o && syndrome_o > CHK_W'(CW_W)));
endmodule

bind ham_ecc_path ham_ecc_path_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .data_i       (data_i),
  .fault_sel_i  (fault_sel_i),
  .fault_mask_i (fault_mask_i),
  .data_o       (data_o),
  .syndrome_o   (syndrome_o),
  .err_o        (err_o),
  .uncorr_o     (uncorr_o)
);

// File: tb/ham_ecc_path_test.sv
module ham_ecc_path_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  din = '0;
  logic        fsel = 1'b0;
  logic [11:0] fmask = '0;
  logic [7:0]  dout;
  logic [3:0]  syn;
  logic        err;
  logic        unc;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic [3:0] s;
    logic       e;
    logic       u;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  ham_ecc_path uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .valid_i      (valid),
    .data_i       (din),
    .fault_sel_i  (fsel),
    .fault_mask_i (fmask),
    .data_o       (dout),
    .syndrome_o   (syn),
    .err_o        (err),
    .uncorr_o     (unc)
  );

  // reference model built from the requirements
  function automatic logic [11:0] m_enc(input logic [7:0] d);
    int dp [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
    logic [11:0] cw;
    logic par;
    cw = '0;
    for (int i = 0; i < 8; i++) cw[dp[i]-1] = d[i];
    for (int k = 0; k < 4; k++) begin
      par = 1'b0;
      for (int i = 0; i < 8; i++) if (((dp[i] >> k) & 1) == 1) par ^= d[i];
      cw[(1 << k) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [3:0] m_syn(input logic [11:0] cw);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= 12; p++) if (cw[p-1]) s ^= 4'(p);
    return s;
  endfunction

  function automatic logic [7:0] m_extract(input logic [11:0] cw);
    int dp [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
    logic [7:0] d;
    for (int i = 0; i < 8; i++) d[i] = cw[dp[i]-1];
    return d;
  endfunction

  task automatic send(input logic [7:0] d, input logic sel, input logic [11:0] mask, input string tag);
    exp_t x;
    logic [11:0] rx;
    @(negedge clk);
    din = d; fsel = sel; fmask = mask; valid = 1'b1;
    rx = sel ? (m_enc(d) ^ mask) : m_enc(d);
    x.s = m_syn(rx);
    x.e = (x.s != 0);
    x.u = (x.s > 4'd12);
    if (x.s >= 1 && x.s <= 12) rx[x.s-1] = ~rx[x.s-1];
    x.d = m_extract(rx);
    x.tag = tag;
    exp_q.push_back(x);
    last_exp = x;
  endtask

  task automatic idle(input logic [7:0] d, input logic sel, input logic [11:0] mask);
    @(negedge clk);
    din = d; fsel = sel; fmask = mask; valid = 1'b0;
  endtask

  // monitor: compare each loaded result against the scoreboard
  always @(posedge clk) begin
    if (rst_n && valid) begin
      #2;
      if (exp_q.size() != 0) begin
        exp_t x;
        x = exp_q.pop_front();
        n_checks++;
        if (dout !== x.d || syn !== x.s || err !== x.e || unc !== x.u) begin
          n_errors++;
          $display("FAIL %s: got data=%h syn=%0d err=%b unc=%b, expected data=%h syn=%0d err=%b unc=%b",
                   x.tag, dout, syn, err, unc, x.d, x.s, x.e, x.u);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81, 8'h3C};
    // R11 reset state
    #12;
    n_checks++;
    if (dout !== 8'h00 || syn !== 4'h0 || err !== 1'b0 || unc !== 1'b0) begin
      n_errors++;
      $display("FAIL R11: got %h/%0d/%b/%b, expected 00/0/0/0", dout, syn, err, unc);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3 with R2: clean path under varied bytes and nonzero masks
    for (int i = 0; i < 6; i++) send(pats[i], 1'b0, 12'hFFF ^ 12'(i * 37), "R3");

    // R4: fault path with an empty mask
    send(8'h96, 1'b1, 12'h000, "R4");

    // R5/R6/R7/R9: single flips at every position
    for (int p = 1; p <= 12; p++)
      send(8'hC3, 1'b1, 12'(1) << (p - 1), ((p & (p - 1)) == 0) ? "R7" : "R6");
    for (int p = 1; p <= 12; p++)
      send(8'h1E, 1'b1, 12'(1) << (p - 1), "R5");

    // R1/R9: positions 3 and 5 alias to position 6 and miscorrect d2
    send(8'hC3, 1'b1, 12'h014, "R1");
    // R9: positions 4 and 8 alias to position 12
    send(8'h5A, 1'b1, 12'h088, "R9");
    // R8: syndromes 13, 14 and 15
    send(8'h3C, 1'b1, 12'h090, "R8");
    send(8'hE7, 1'b1, 12'h140, "R8");
    send(8'h42, 1'b1, 12'h120, "R8");

    // R10: no load while valid is low
    idle(8'h11, 1'b1, 12'h001);
    idle(8'h22, 1'b1, 12'h090);
    @(negedge clk);
    n_checks++;
    if (dout !== last_exp.d || syn !== last_exp.s || err !== last_exp.e || unc !== last_exp.u) begin
      n_errors++;
      $display("FAIL R10: got %h/%0d/%b/%b, expected %h/%0d/%b/%b",
               dout, syn, err, unc, last_exp.d, last_exp.s, last_exp.e, last_exp.u);
    end

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_errors++;
      n_checks++;
      $display("FAIL R10: got %0d unchecked results, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule